// File: doc/BRIEF.md
# Dual-Mode Pixel Photon Counter and Time-to-Digital Converter

This block is the digital back end of one pixel of a single-photon detector array. Each frame runs in one of two modes. In counting mode it counts the detector pulses that arrive during the frame. In timing mode it measures the interval from the pixel's first detector pulse (START) to a STOP strobe that all pixels share. Only one counter is used. It is the photon counter in counting mode and the coarse stage of the converter in timing mode.

In timing mode both edges are phase-interpolated. An external multiphase sampler supplies two 16-bit thermometer snapshots, one taken at START and one taken at STOP. The block decodes each snapshot to a 4-bit phase. It then forms the result as coarse cycles × 16 + STOP phase − START phase, so equal intervals fall on different parts of the fine scale. At 250 MHz one coarse step is 4 ns, one fine step is 250 ps, and full scale is 256 ns.

The frame sequencer is a state machine with seven states:
- `ST_IDLE`: between frames, with the result held.
- `ST_OFF`: a disabled frame.
- `ST_COUNT`: counting mode.
- `ST_ARMED`: timing mode, waiting for START.
- `ST_RUN`: coarse counting, waiting for STOP.
- `ST_DONE`: the conversion is latched.
- `ST_OVF`: the coarse range was exceeded.

Its transitions are as follows:
- From `ST_IDLE`, a frame-open pulse enters `ST_OFF`, `ST_COUNT` or `ST_ARMED`, according to the enable and mode.
- `ST_ARMED` goes to `ST_RUN` on a detector pulse.
- `ST_RUN` goes to `ST_DONE` on STOP.
- `ST_RUN` goes to `ST_OVF` when the counter sits at 63 and no STOP comes.
- Every active state returns to `ST_IDLE` on frame close. A frame-open pulse received in an active state restarts the frame.

Top module: `pix_tdc_core`

## Requirements
- R1: While reset is asserted and after it is released, `result` is 0 and `result_vld` is 0 until the first frame closes.
- R2: A thermometer snapshot (bit 0 is the earliest phase) decodes to phase i+1. Here i is the lowest index from 0 to 14 where bit i is 1 and bit i+1 is 0. Bits above that point are ignored. A word with no such transition (all ones or all zeros) decodes to phase 0.
- R3: In timing mode the result is C×16 + P_stop − P_start, with `result_vld` = 1. C is the number of clock edges from the edge that samples START to the edge that samples STOP, and is between 1 and 63. P_start and P_stop are the decoded phases.
- R4: In timing mode only the first detector pulse of a frame is converted, and later pulses are ignored. A STOP that arrives before any START is ignored.
- R5: If STOP has not come by frame close, or C would reach 64, the result is the overflow code 1023 (all ones) with `result_vld` = 1.
- R6: A timing frame with no START reports 0 with `result_vld` = 0.
- R7: In counting mode the result is the number of cycles in which `det_pulse` was high. This count saturates at 63, and bits [9:6] are 0. `result_vld` = 1.
- R8: If `pix_en` is low when the frame opens, the frame reports 0 with `result_vld` = 0, in either mode.
- R9: The output registers update on the edge that samples `frame_close`. They hold until a `frame_open`, which clears them to 0/0. Mode and enable are sampled at `frame_open`. Detector and STOP events in a `frame_open` or `frame_close` cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (coarse time base) |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_open | input | 1 | One-cycle pulse that starts a frame |
| frame_close | input | 1 | One-cycle pulse that ends a frame and latches the result |
| pix_en | input | 1 | Pixel enable, sampled at frame open |
| mode_timing | input | 1 | 1 = timing mode, 0 = counting mode, sampled at frame open |
| det_pulse | input | 1 | Synchronised detector pulse (START) |
| det_therm | input | 16 | Thermometer phase snapshot taken at the detector pulse |
| stop_strobe | input | 1 | Shared STOP strobe |
| stop_therm | input | 16 | Global thermometer phase snapshot taken at STOP |
| result | output | 10 | Frame result (count or interval) |
| result_vld | output | 1 | Result holds an event |

## Verification
The bench covers the following corner cases:
- The shortest and longest legal intervals (C = 1 with the START phase above the STOP phase, and C = 63). C = 64 must give the overflow code. A design with an off-by-one coarse count reports 1008 + Δ as 1023, or wraps to a small value.
- Thermometer words with bubbles, and all-ones words. A decoder that finds the highest set bit, or counts ones, gives the wrong phase.
- A second START before STOP, and a STOP before START. A design that restarts on every pulse reports a shorter interval.
- Counting past 63, which a wrapping counter would report as a small value.
- Holding the result after close while events keep arriving, clearing it at open, and disabled frames. A design that keeps listening outside the frame changes the held word.

// File: rtl/pixtdc_pkg.sv
`timescale 1ns/1ps
package pixtdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFF,
        ST_COUNT,
        ST_ARMED,
        ST_RUN,
        ST_DONE,
        ST_OVF
    } pix_state_e;
endpackage

// File: rtl/therm_decode.sv
`timescale 1ns/1ps
module therm_decode #(
    parameter int PHASES = 16,
    localparam int FW = $clog2(PHASES)
) (
    input  logic [PHASES-1:0] therm,
    output logic [FW-1:0]     phase
);
    logic found;

    always_comb begin
        phase = '0;
        found = 1'b0;
        for (int i = 0; i < PHASES - 1; i++) begin
            if (!found && therm[i] && !therm[i+1]) begin
                phase = FW'(i + 1);
                found = 1'b1;
            end
        end
    end

    // R2
    always_comb begin
        if (therm == '1 || therm == '0) begin
            flat_word_chk: assert (phase == '0);
        end
        if (therm[0] && !therm[1]) begin
            first_edge_chk: assert (phase == FW'(1));
        end
    end
endmodule

// File: rtl/evt_counter.sv
`timescale 1ns/1ps
module evt_counter #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          inc,
    output logic [CW-1:0] q,
    output logic          at_max
);
    assign at_max = (q == '1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (inc && !at_max) begin
            q <= q + CW'(1);
        end
    end

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && inc && !load) |=> at_max);

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_max && inc && !load) |=> (q == $past(q) + CW'(1)));
endmodule

// File: rtl/pix_tdc_core.sv
`timescale 1ns/1ps
module pix_tdc_core
    import pixtdc_pkg::*;
#(
    parameter int PHASES = 16,
    parameter int CW     = 6,
    localparam int FW    = $clog2(PHASES),
    localparam int RW    = CW + FW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_open,
    input  logic              frame_close,
    input  logic              pix_en,
    input  logic              mode_timing,
    input  logic              det_pulse,
    input  logic [PHASES-1:0] det_therm,
    input  logic              stop_strobe,
    input  logic [PHASES-1:0] stop_therm,
    output logic [RW-1:0]     result,
    output logic              result_vld
);
    pix_state_e state_q, state_d, entry_st;

    logic [FW-1:0] det_ph, stop_ph, start_ph_q;
    logic [RW-1:0] conv_q;
    logic [CW-1:0] cnt_q, cnt_load_val;
    logic          cnt_at_max, cnt_load, cnt_inc;
    logic          go_start, evt_ok, take_start, take_stop;

    therm_decode #(.PHASES(PHASES)) i_dec_start (.therm(det_therm),  .phase(det_ph));
    therm_decode #(.PHASES(PHASES)) i_dec_stop  (.therm(stop_therm), .phase(stop_ph));

    evt_counter #(.CW(CW)) i_ctr (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
        .inc(cnt_inc), .q(cnt_q), .at_max(cnt_at_max)
    );

    // frame control decode
    assign go_start   = (state_q == ST_IDLE) ? frame_open : (frame_open && !frame_close);
    assign evt_ok     = (state_q != ST_IDLE) && !frame_open && !frame_close;
    assign take_start = (state_q == ST_ARMED) && det_pulse && evt_ok;
    assign take_stop  = (state_q == ST_RUN) && stop_strobe && evt_ok;

    always_comb begin
        if (!pix_en)          entry_st = ST_OFF;
        else if (mode_timing) entry_st = ST_ARMED;
        else                  entry_st = ST_COUNT;
    end

    // counter control: clear at frame start, preset to one at START
    always_comb begin
        cnt_load     = go_start || take_start;
        cnt_load_val = take_start ? CW'(1) : '0;
        cnt_inc      = evt_ok && (((state_q == ST_COUNT) && det_pulse) ||
                                  ((state_q == ST_RUN) && !stop_strobe));
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (go_start) begin
            state_d = entry_st;
        end else if (state_q != ST_IDLE && frame_close) begin
            state_d = ST_IDLE;
        end else if (evt_ok) begin
            unique case (state_q)
                ST_ARMED: if (det_pulse) state_d = ST_RUN;
                ST_RUN: begin
                    if (stop_strobe)     state_d = ST_DONE;
                    else if (cnt_at_max) state_d = ST_OVF;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and conversion registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            result_vld <= 1'b0;
            start_ph_q <= '0;
            conv_q     <= '0;
        end else begin
            if (go_start) begin
                result     <= '0;
                result_vld <= 1'b0;
            end else if (state_q != ST_IDLE && frame_close) begin
                unique case (state_q)
                    ST_COUNT: begin
                        result     <= RW'(cnt_q);
                        result_vld <= 1'b1;
                    end
                    ST_DONE: begin
                        result     <= conv_q;
                        result_vld <= 1'b1;
                    end
                    ST_RUN, ST_OVF: begin
                        result     <= '1;
                        result_vld <= 1'b1;
                    end
                    ST_ARMED, ST_OFF, ST_IDLE: begin
                        result     <= '0;
                        result_vld <= 1'b0;
                    end
                endcase
            end
            if (take_start) start_ph_q <= det_ph;
            if (take_stop)  conv_q <= {cnt_q, {FW{1'b0}}} + RW'(stop_ph) - RW'(start_ph_q);
        end
    end

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frame_open) |=> ($stable(result) && $stable(result_vld)));

    // R6
    novalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_vld |-> (result == '0));

    // R8
    off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && frame_close) |=> !result_vld);

    // R4
    first_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && det_pulse && evt_ok && !stop_strobe && !cnt_at_max)
        |=> (state_q == ST_RUN && cnt_q == $past(cnt_q) + CW'(1)));

    // R5
    ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && evt_ok && !stop_strobe && cnt_at_max) |=> (state_q == ST_OVF));

    // R5
    ovf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OVF && frame_close) |=> (result == '1 && result_vld));
endmodule

// File: tb/test_pix_tdc_core.sv
`timescale 1ns/1ps
module test_pix_tdc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_open = 1'b0, frame_close = 1'b0;
    logic        pix_en = 1'b0, mode_timing = 1'b0;
    logic        det_pulse = 1'b0, stop_strobe = 1'b0;
    logic [15:0] det_therm = '0, stop_therm = '0;
    logic [9:0]  result;
    logic        result_vld;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pix_tdc_core i_pix_tdc_core (
        .clk(clk), .rst_n(rst_n), .frame_open(frame_open), .frame_close(frame_close),
        .pix_en(pix_en), .mode_timing(mode_timing), .det_pulse(det_pulse),
        .det_therm(det_therm), .stop_strobe(stop_strobe), .stop_therm(stop_therm),
        .result(result), .result_vld(result_vld)
    );

    // vector fields: [16] timing mode, [15] enable, [14:8] n, [7:4] start phase, [3:0] stop phase
    localparam logic [16:0] VECS [0:7] = '{
        {1'b1, 1'b1, 7'd5,  4'd3,  4'd9},
        {1'b1, 1'b1, 7'd1,  4'd15, 4'd0},
        {1'b1, 1'b1, 7'd20, 4'd0,  4'd15},
        {1'b1, 1'b1, 7'd63, 4'd7,  4'd2},
        {1'b1, 1'b0, 7'd10, 4'd2,  4'd4},
        {1'b0, 1'b1, 7'd0,  4'd0,  4'd0},
        {1'b0, 1'b1, 7'd17, 4'd0,  4'd0},
        {1'b0, 1'b0, 7'd9,  4'd0,  4'd0}
    };

    function automatic logic [15:0] th(int p);
        return (p == 0) ? 16'h0000 : 16'((32'h1 << p) - 1);
    endfunction

    function automatic logic [9:0] exp_time(int n, int st, int sp);
        return (n > 63) ? 10'h3FF : 10'(n * 16 + sp - st);
    endfunction

    task automatic chk(string tag, logic [9:0] er, logic ev);
        n_cmp++;
        if (result !== er || result_vld !== ev) begin
            n_bad++;
            $display("FAIL %s: result=%0d vld=%b expected result=%0d vld=%b",
                     tag, result, result_vld, er, ev);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_frame(logic md, logic en);
        mode_timing = md;
        pix_en      = en;
        frame_open  = 1'b1;
        @(negedge clk);
        frame_open  = 1'b0;
        idle(1);
    endtask

    task automatic close_frame();
        frame_close = 1'b1;
        @(negedge clk);
        frame_close = 1'b0;
    endtask

    task automatic do_start(logic [15:0] t);
        det_pulse = 1'b1;
        det_therm = t;
        @(negedge clk);
        det_pulse = 1'b0;
    endtask

    task automatic do_stop(logic [15:0] t);
        stop_strobe = 1'b1;
        stop_therm  = t;
        @(negedge clk);
        stop_strobe = 1'b0;
    endtask

    // STOP sampled n edges after the edge that samples START
    task automatic timing_run(logic [15:0] st, int n, logic [15:0] sp);
        do_start(st);
        idle(n - 1);
        do_stop(sp);
        idle(1);
    endtask

    task automatic count_pulses(int n);
        repeat (n) begin
            det_pulse = 1'b1;
            @(negedge clk);
            det_pulse = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: result=%0d vld=%b expected run to end", result, result_vld);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [16:0] e;
        int          n, st, sp;

        repeat (3) @(negedge clk);
        chk("R1 during reset", 10'd0, 1'b0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 after reset", 10'd0, 1'b0);

        for (int v = 0; v < 8; v++) begin
            e  = VECS[v];
            n  = int'(e[14:8]);
            st = int'(e[7:4]);
            sp = int'(e[3:0]);
            open_frame(e[16], e[15]);
            if (e[16]) timing_run(th(st), n, th(sp));
            else       count_pulses(n);
            close_frame();
            if (!e[15])     chk("R8 disabled frame", 10'd0, 1'b0);
            else if (e[16]) chk("R3 timing vector", exp_time(n, st, sp), 1'b1);
            else            chk("R7 counting vector", 10'(n), 1'b1);
            idle(1);
        end

        // R2 bubble in START word: 0x0407 decodes to phase 3
        open_frame(1'b1, 1'b1);
        timing_run(16'h0407, 4, th(8));
        close_frame();
        chk("R2 bubble start", exp_time(4, 3, 8), 1'b1);

        // R2 all-ones STOP word decodes to 0
        open_frame(1'b1, 1'b1);
        timing_run(th(2), 3, 16'hFFFF);
        close_frame();
        chk("R2 all ones stop", exp_time(3, 2, 0), 1'b1);

        // R4 second START ignored: STOP 5 edges after first START
        open_frame(1'b1, 1'b1);
        do_start(th(4));
        idle(2);
        do_start(th(9));
        idle(1);
        do_stop(th(6));
        idle(1);
        close_frame();
        chk("R4 second start", exp_time(5, 4, 6), 1'b1);

        // R4 STOP before START ignored
        open_frame(1'b1, 1'b1);
        do_stop(th(5));
        idle(2);
        timing_run(th(1), 3, th(3));
        close_frame();
        chk("R4 early stop", exp_time(3, 1, 3), 1'b1);

        // R5 no STOP in frame
        open_frame(1'b1, 1'b1);
        do_start(th(6));
        idle(10);
        close_frame();
        chk("R5 missing stop", 10'h3FF, 1'b1);

        // R5 coarse range exceeded (C = 64)
        open_frame(1'b1, 1'b1);
        timing_run(th(0), 64, th(1));
        close_frame();
        chk("R5 coarse overflow", 10'h3FF, 1'b1);

        // R6 timing frame without START
        open_frame(1'b1, 1'b1);
        do_stop(th(4));
        idle(5);
        close_frame();
        chk("R6 no start", 10'd0, 1'b0);

        // R7 saturation at 63 with 70 back-to-back pulses
        open_frame(1'b0, 1'b1);
        det_pulse = 1'b1;
        idle(70);
        det_pulse = 1'b0;
        idle(1);
        close_frame();
        chk("R7 saturate", 10'd63, 1'b1);

        // R9 pulse in close cycle ignored, then held while events arrive
        open_frame(1'b0, 1'b1);
        count_pulses(3);
        det_pulse   = 1'b1;
        frame_close = 1'b1;
        @(negedge clk);
        frame_close = 1'b0;
        chk("R9 close-cycle pulse ignored", 10'd3, 1'b1);
        stop_strobe = 1'b1;
        idle(6);
        det_pulse   = 1'b0;
        stop_strobe = 1'b0;
        chk("R9 held after close", 10'd3, 1'b1);

        // R9 cleared at frame open
        frame_open  = 1'b1;
        mode_timing = 1'b0;
        pix_en      = 1'b1;
        @(negedge clk);
        frame_open  = 1'b0;
        chk("R9 cleared at open", 10'd0, 1'b0);
        idle(2);
        close_frame();
        chk("R7 zero count", 10'd0, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule